// File: doc/BRIEF.md
# Serial ADC Frame Reader

This block is the host side of a link to a 14-bit serial converter. On a start request it pulls the chip select low and issues exactly 18 serial clock periods. It samples the converter's data line on each falling clock edge and then releases the chip select. The 14 data bits of the frame come back as one parallel word with a one-cycle valid strobe. The converter always shifts out the conversion of the sample it took at the previous chip-select fall. As a result, the first result after reset carries no real sample and is flagged stale.

The serial clock half period is a whole number of system clocks, set by an input that is latched when each frame begins. Between frames the block keeps the chip select high for a minimum time. It also spaces successive chip-select falls by a minimum cycle time. A start request that arrives too early is held and served as soon as both minimums are met. A continuous-mode input restarts frames on its own at the earliest allowed cycle. In every frame the block checks that the framing bits (the leading bit and the three trailing bits) read as zero, and it flags the result when they do not.

Top module: `adc_frame_reader`

## Requirements
- R1: While reset is asserted and after it is released with no request, cs_n_o and sclk_o are 1, valid_o is 0, and data_o, stale_o and frame_err_o are 0.
- R2: A frame holds cs_n_o low for SETUP_CLKS + 36·h system clocks and contains exactly 18 falling edges of sclk_o. Here h is half_div_i latched at the chip-select fall, with 0 treated as 1. sclk_o stays high and does not move while cs_n_o is high.
- R3: Within a frame, every high phase and every low phase of sclk_o lasts exactly h system clocks.
- R4: The first sclk_o falling edge comes SETUP_CLKS clocks after cs_n_o falls. cs_n_o rises h clocks after the last sclk_o rising edge.
- R5: Bit k of a frame (k = 0..17) is sampled from sdo_i on the k-th falling edge of sclk_o. Bits 1 to 14 form data_o with bit 1 in data_o[13] and bit 14 in data_o[0].
- R6: valid_o is high for exactly one clock, at the same edge where cs_n_o rises. data_o, stale_o and frame_err_o keep their values until the next valid_o.
- R7: frame_err_o, updated with valid_o, is 1 exactly when bit 0 or any of bits 15, 16 or 17 of that frame was read as 1.
- R8: stale_o is 1 with the first result after reset and 0 with every later result.
- R9: cs_n_o stays high for at least CS_HIGH_MIN clocks between frames. When a request is waiting and the cycle time is already met, the next fall comes exactly CS_HIGH_MIN clocks after the rise.
- R10: Successive cs_n_o falls are at least CYCLE_MIN clocks apart. When a request is waiting and the high time is already met, the next fall comes exactly CYCLE_MIN clocks after the previous one.
- R11: A start_i pulse that cannot be served at once is remembered (one deep). Any number of pulses during one frame or gap yield exactly one further frame.
- R12: While cont_i is high, frames follow each other at the earliest allowed cycle. Once cont_i is low, the frame in progress completes and no further frame starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request one frame |
| cont_i | input | 1 | Continuous frame mode |
| half_div_i | input | DIV_W | Serial clock half period in system clocks (0 acts as 1) |
| sdo_i | input | 1 | Serial data from the converter |
| cs_n_o | output | 1 | Active-low chip select |
| sclk_o | output | 1 | Serial clock, idle high |
| data_o | output | DATA_W | Result word of the last frame |
| valid_o | output | 1 | One-clock result strobe |
| stale_o | output | 1 | Result belongs to no real sample (first after reset) |
| frame_err_o | output | 1 | A framing bit read as 1 in the last frame |

## Verification
The end of a frame can land in the same clock as a fresh start request: cs_n_o rises, valid_o fires and start_i is high all at once. The bench holds start_i high across the final high phase of sclk_o so that it covers the edge where the frame closes. It then judges the outcome on three points. The result of the closing frame must be reported intact. Exactly one further frame must follow. That frame's chip-select fall must come exactly CS_HIGH_MIN clocks after the rise, not earlier and not lost.

// File: rtl/adc_frame_reader.sv
module adc_frame_reader #(
  parameter int DATA_W      = 14,
  parameter int FRAME_CLKS  = 18,
  parameter int DIV_W       = 8,
  parameter int SETUP_CLKS  = 2,
  parameter int CS_HIGH_MIN = 4,
  parameter int CYCLE_MIN   = 100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              cont_i,
  input  logic [DIV_W-1:0]  half_div_i,
  input  logic              sdo_i,
  output logic              cs_n_o,
  output logic              sclk_o,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o,
  output logic              stale_o,
  output logic              frame_err_o
);

  localparam int BW = $clog2(FRAME_CLKS + 1);
  localparam int HW = $clog2(CS_HIGH_MIN + 1);
  localparam int CW = $clog2(CYCLE_MIN + 1);
  localparam logic [BW-1:0]    LAST_BIT = BW'(FRAME_CLKS);
  localparam logic [BW-1:0]    DLAST    = BW'(DATA_W);
  localparam logic [HW-1:0]    HI_LIM   = HW'(CS_HIGH_MIN);
  localparam logic [CW-1:0]    CYC_LIM  = CW'(CYCLE_MIN);
  localparam logic [DIV_W-1:0] SET_LD   = DIV_W'(SETUP_CLKS - 1);

  typedef enum logic [1:0] {IDLE, SETUP, SHIFT} st_t;

  st_t               st;
  logic [DIV_W-1:0]  div_cnt, hd_q;
  logic [BW-1:0]     bit_cnt;
  logic [DATA_W-1:0] sh;
  logic              pad_bad, first, pend;
  logic [HW-1:0]     hi_cnt;
  logic [CW-1:0]     cyc_cnt;

  wire [DIV_W-1:0] hd_in = (half_div_i == '0) ? DIV_W'(1) : half_div_i;
  wire tick     = (div_cnt == '0);
  wire gap_ok   = (hi_cnt >= HI_LIM) && (cyc_cnt >= CYC_LIM);
  wire go       = (st == IDLE) && (pend || start_i || cont_i) && gap_ok;
  wire done     = (st == SHIFT) && tick && sclk_o && (bit_cnt == LAST_BIT);
  wire fall_now = ((st == SETUP) && tick) ||
                  ((st == SHIFT) && tick && sclk_o && (bit_cnt != LAST_BIT));
  wire is_data  = (bit_cnt != '0) && (bit_cnt <= DLAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= IDLE;
      cs_n_o      <= 1'b1;
      sclk_o      <= 1'b1;
      div_cnt     <= '0;
      hd_q        <= DIV_W'(1);
      bit_cnt     <= '0;
      sh          <= '0;
      pad_bad     <= 1'b0;
      first       <= 1'b1;
      pend        <= 1'b0;
      hi_cnt      <= HI_LIM;
      cyc_cnt     <= CYC_LIM;
      data_o      <= '0;
      valid_o     <= 1'b0;
      stale_o     <= 1'b0;
      frame_err_o <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (cyc_cnt < CYC_LIM) cyc_cnt <= cyc_cnt + 1'b1;
      if (cs_n_o && hi_cnt < HI_LIM) hi_cnt <= hi_cnt + 1'b1;
      if (start_i) pend <= 1'b1;
      if (!tick) div_cnt <= div_cnt - 1'b1;

      case (st)
        IDLE: if (go) begin
          st      <= SETUP;
          cs_n_o  <= 1'b0;
          cyc_cnt <= CW'(1);
          pend    <= 1'b0;
          hd_q    <= hd_in;
          div_cnt <= SET_LD;
          bit_cnt <= '0;
          pad_bad <= 1'b0;
        end
        SETUP: if (tick) st <= SHIFT;
        SHIFT: if (tick && !sclk_o) begin
          sclk_o  <= 1'b1;
          div_cnt <= hd_q - 1'b1;
        end else if (done) begin
          st          <= IDLE;
          cs_n_o      <= 1'b1;
          hi_cnt      <= HW'(1);
          valid_o     <= 1'b1;
          data_o      <= sh;
          stale_o     <= first;
          first       <= 1'b0;
          frame_err_o <= pad_bad;
        end
        default: st <= IDLE;
      endcase

      if (fall_now) begin
        sclk_o  <= 1'b0;
        div_cnt <= hd_q - 1'b1;
        bit_cnt <= bit_cnt + 1'b1;
        if (is_data) sh <= {sh[DATA_W-2:0], sdo_i};
        else if (sdo_i) pad_bad <= 1'b1;
      end
    end
  end

  a_r2_sclk_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_o |-> sclk_o);
  a_r2_sclk_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n_o && $past(cs_n_o)) |-> $stable(sclk_o));
  a_r4_cs_fall_clock_high: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n_o) |-> sclk_o);
  a_r5_bit_bound: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= LAST_BIT);
  a_r6_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);
  a_r6_valid_at_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n_o) |-> valid_o);
  a_r9_cs_high_min: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n_o) |-> ($past(hi_cnt) >= HI_LIM));

endmodule

// File: tb/adc_frame_reader_tb.sv
module adc_frame_reader_tb;
  localparam int S = 2, HMIN = 4, CMIN = 100;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, cont = 1'b0, sdo = 1'b0;
  logic [7:0] hdiv = 8'd1;
  logic cs_n, sclk, valid, stale, err;
  logic [13:0] data;

  always #2 clk = ~clk;

  adc_frame_reader u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .cont_i(cont),
    .half_div_i(hdiv), .sdo_i(sdo), .cs_n_o(cs_n), .sclk_o(sclk),
    .data_o(data), .valid_o(valid), .stale_o(stale), .frame_err_o(err)
  );

  int cyc = 0, nchk = 0, nfail = 0;
  int nvalid = 0, t_valid = 0;
  logic [13:0] cap_data = '0;
  logic cap_stale = 1'b0, cap_err = 1'b0;

  always @(negedge clk) begin
    if (valid) begin
      nvalid++; t_valid = cyc;
      cap_data = data; cap_stale = stale; cap_err = err;
    end
    cyc++;
  end

  int nfall = 0, t_fall = 0, t_fall_prev = 0, t_rise = 0;
  int t_sf0 = 0, nsf = 0, t_sr = 0, t_sf = 0;
  int hi_min = 999, hi_max = 0, lo_min = 999, lo_max = 0;

  always @(negedge cs_n) begin
    t_fall_prev = t_fall; t_fall = cyc; nfall++; nsf = 0;
    hi_min = 999; hi_max = 0; lo_min = 999; lo_max = 0;
  end
  always @(posedge cs_n) t_rise = cyc;
  always @(negedge sclk) if (cs_n == 1'b0) begin
    if (nsf == 0) t_sf0 = cyc;
    else begin
      if (cyc - t_sr < hi_min) hi_min = cyc - t_sr;
      if (cyc - t_sr > hi_max) hi_max = cyc - t_sr;
    end
    t_sf = cyc; nsf++;
  end
  always @(posedge sclk) if (cs_n == 1'b0) begin
    if (cyc - t_sf < lo_min) lo_min = cyc - t_sf;
    if (cyc - t_sf > lo_max) lo_max = cyc - t_sf;
    t_sr = cyc;
  end

  logic [13:0] samp [0:7];
  logic [13:0] held = '0, sent = '0;
  int fidx = 0, bidx = 0;
  logic inj_lead = 1'b0, inj_tail = 1'b0;

  function automatic logic bitv(int i, logic [13:0] w);
    if (i >= 1 && i <= 14) return w[14-i];
    if (i == 0) return inj_lead;
    if (i == 17) return inj_tail;
    return 1'b0;
  endfunction

  always @(negedge cs_n) begin
    sent = held; held = samp[fidx % 8]; fidx++; bidx = 0;
    sdo <= #1 bitv(0, sent);
  end
  always @(posedge sclk) if (cs_n == 1'b0) begin
    bidx++;
    sdo <= #1 bitv(bidx, sent);
  end
  always @(posedge cs_n) sdo <= #1 1'b0;

  task automatic chk(string req, int act, int exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic wait_valid(int target);
    while (nvalid < target) @(negedge clk);
  endtask

  task automatic wait_fall(int target);
    while (nfall < target) @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 cs_n", cs_n, 1); chk("R1 sclk", sclk, 1); chk("R1 valid", valid, 0);
    chk("R1 data", data, 0); chk("R1 stale", stale, 0); chk("R1 err", err, 0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk("R1 idle cs_n", cs_n, 1); chk("R1 idle sclk", sclk, 1);
  endtask

  task automatic t_frame(int hd, int exp_stale);
    int v = nvalid;
    int h = (hd == 0) ? 1 : hd;
    hdiv = 8'(hd);
    pulse_start();
    wait_valid(v + 1);
    chk("R2 cs low length", t_rise - t_fall, S + 36 * h);
    chk("R2 falling edges", nsf, 18);
    chk("R3 high min", hi_min, h); chk("R3 high max", hi_max, h);
    chk("R3 low min", lo_min, h);  chk("R3 low max", lo_max, h);
    chk("R4 setup", t_sf0 - t_fall, S);
    chk("R4 hold", t_rise - t_sr, h);
    chk("R5 data", cap_data, sent);
    chk("R6 valid with cs rise", t_valid, t_rise);
    chk("R8 stale", cap_stale, exp_stale);
    chk("R7 clean frame", cap_err, 0);
    repeat (10) @(negedge clk);
    chk("R6 pulse ended", valid, 0);
    chk("R6 data held", data, sent);
    chk("R6 stale held", stale, exp_stale);
  endtask

  task automatic t_error();
    int v;
    hdiv = 8'd2;
    inj_lead = 1'b1; v = nvalid; pulse_start(); wait_valid(v + 1); inj_lead = 1'b0;
    chk("R7 leading one", cap_err, 1);
    chk("R5 data with lead error", cap_data, sent);
    inj_tail = 1'b1; v = nvalid; pulse_start(); wait_valid(v + 1); inj_tail = 1'b0;
    chk("R7 trailing one", cap_err, 1);
    v = nvalid; pulse_start(); wait_valid(v + 1);
    chk("R7 clean again", cap_err, 0);
    chk("R5 clean data", cap_data, sent);
  endtask

  task automatic t_pending();
    int f = nfall;
    hdiv = 8'd1;
    pulse_start();
    wait_fall(f + 1);
    repeat (3) begin
      repeat (5) @(negedge clk);
      pulse_start();
    end
    wait_fall(f + 2);
    chk("R10 fall spacing", t_fall - t_fall_prev, CMIN);
    repeat (250) @(negedge clk);
    chk("R11 one extra frame", nfall, f + 2);
  endtask

  task automatic t_cont();
    int f = nfall;
    hdiv = 8'd3;
    @(negedge clk) cont = 1'b1;
    wait_fall(f + 1);
    for (int k = 2; k <= 4; k++) begin
      wait_fall(f + k);
      chk("R12 back-to-back spacing", t_fall - t_fall_prev, S + 108 + HMIN);
      chk("R9 cs high time", t_fall - t_rise, HMIN);
    end
    @(negedge clk) cont = 1'b0;
    repeat (300) @(negedge clk);
    chk("R12 stops after clear", nfall, f + 4);
    chk("R12 idle cs", cs_n, 1);
  endtask

  task automatic t_coincide();
    int f = nfall, v = nvalid, tr;
    hdiv = 8'd3;
    pulse_start();
    wait_fall(f + 1);
    while (nsf < 18) @(negedge clk);
    @(negedge clk) start = 1'b1;
    repeat (8) @(negedge clk);
    start = 1'b0;
    wait_valid(v + 1);
    tr = t_rise;
    chk("R6 result at coincident request", cap_data, sent);
    wait_valid(v + 2);
    chk("R9 restart after coincident request", t_fall - tr, HMIN);
    repeat (250) @(negedge clk);
    chk("R11 coincident request served once", nfall, f + 2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    samp[0] = 14'h3FFF; samp[1] = 14'h2AAA; samp[2] = 14'h1555; samp[3] = 14'h0001;
    samp[4] = 14'h2000; samp[5] = 14'h1234; samp[6] = 14'h0F0F; samp[7] = 14'h3001;
    t_reset();
    t_frame(1, 1);
    t_frame(3, 0);
    t_frame(0, 0);
    t_error();
    t_pending();
    t_cont();
    t_coincide();
    summary();
    $finish;
  end
endmodule